// File: doc/BRIEF.md
# NAND Device Command Front-End

This block is the device-side bus logic of a NAND-style memory. It watches an 8-bit multiplexed bus plus chip-select, command-strobe, address-strobe, write-strobe and read-strobe pins, all sampled on a system clock. On each rising write-strobe with the chip selected, it steers the byte to the command decoder, the address assembler or the page buffer. Which path it takes depends on the two strobes.

Operations are built from a setup command, a fixed number of address cycles and a confirm command. A complete, matching pair starts the operation. The block then reports the operation kind and row address to the array engine and holds the ready/busy line low for a configurable number of clock cycles. Column addressing drives a pointer into a small behavioural page buffer. Each falling read-strobe moves one byte from the buffer, the identification word or the status byte into an output register. A single command then moves the pointer to another column in the same page.

Top module: `nand_cmd_frontend`

## Requirements
- R1: A byte is taken only on a rising `we_n` while `ce_n` is low. A byte taken with `cle`=1 and `ale`=0 is a command, one with `ale`=1 and `cle`=0 is an address, and one with both low is data. A write with `ce_n` high has no effect and leaves any pending sequence intact.
- R2: The read and program setups (00h, 80h) and the copy-back program setup (85h) are each followed by four address cycles, taken in this order: column bits 7:0, column bits 11:8, row bits 7:0, row bits 15:8. `op_row` presents the assembled row.
- R3: In the second column cycle, bits 7:4 of the byte are discarded. Address cycles beyond the number a setup needs are ignored.
- R4: Erase is 60h, then two row cycles (row bits 7:0, then 15:8), then D0h. It starts an operation of kind 6 with busy length T_ERASE.
- R5: A confirm matching its setup with all addresses taken raises `op_go` for one cycle and sets `op_kind`. The kinds are: 00h/30h gives 1, 00h/35h gives 2, 80h/10h gives 3, 80h/15h gives 4, 85h/10h gives 5, and 60h/D0h gives 6. Kinds 1 and 2 busy for T_READ cycles, 3 and 5 for T_PROG, 4 for T_CACHE and 6 for T_ERASE.
- R6: A data byte taken during a program (after its four address cycles) is written to buffer entry (pointer mod 2^BUF_AW), and the pointer advances. Each falling `re_n` with `ce_n` low loads `io_out` with the byte at the pointer. Unless the block is in status mode or busy, the pointer then advances.
- R7: The column pointer runs from 0 to COLS-1 (2111 by default) and wraps from COLS-1 to 0.
- R8: After reset, `rb`=1, `io_oe`=0, `op_go`=0 and `io_out`=0. `rb` goes low in the cycle an operation starts and stays low for exactly its busy length.
- R9: While busy, only 70h (status mode) and FFh (abort) are acted on. FFh returns `rb` high at once. In status mode a read strobe returns 40h when ready and 00h when busy, so bit 6 is ready and all other bits are zero.
- R10: A confirm that does not match the pending setup, or that comes before all its addresses, clears the pending sequence and starts nothing. An undefined command also clears it.
- R11: `io_oe` is high only while `re_n` is low and either `ce_n` is low or the block is busy.
- R12: 90h clears the pointer and selects ID mode. Successive read strobes then return the bytes of ID_BYTES, least-significant byte first, repeating every four bytes.
- R13: 05h, then two column cycles, then E0h moves the read pointer to the given column without going busy.
- R14: 85h issued after a program's four address cycles takes two column cycles that move the write pointer. Data then continues into the same program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command strobe qualifier |
| ale | input | 1 | Address strobe qualifier |
| we_n | input | 1 | Write strobe; bytes taken on its rising edge |
| re_n | input | 1 | Read strobe; output advances on its falling edge |
| io_in | input | 8 | Bus byte driven by the host |
| io_out | output | 8 | Bus byte driven by the device |
| io_oe | output | 1 | Output enable for the bus drivers |
| rb | output | 1 | Ready (1) / busy (0) |
| op_go | output | 1 | One-cycle pulse when an operation starts |
| op_kind | output | 3 | Kind of the operation last started |
| op_row | output | ROW_W | Assembled row address |

## Verification
If the pending setup or the address count holds a wrong value, the next confirm either fails to raise `op_go` or raises it with the wrong kind. Because the pulse comes on the confirm edge itself, the fault is seen one cycle after the command. A pointer that is off shows as a wrong `io_out` byte on the very next read strobe. The page buffer is swept from several start columns, including the spare area and the wrap point, so that fault cannot hide. A busy counter with a wrong load shows as a low time on `rb` that is off from the expected length. The error is visible only when `rb` rises.

// File: rtl/nand_fe_pkg.sv
// Shared codes and types for the NAND command front-end.
// Assumes an 8-bit bus; command values are fixed by the bus protocol.
package nand_fe_pkg;
    localparam logic [7:0] C_READ_SETUP  = 8'h00;
    localparam logic [7:0] C_READ_GO     = 8'h30;
    localparam logic [7:0] C_CBREAD_GO   = 8'h35;
    localparam logic [7:0] C_PROG_SETUP  = 8'h80;
    localparam logic [7:0] C_PROG_GO     = 8'h10;
    localparam logic [7:0] C_CACHE_GO    = 8'h15;
    localparam logic [7:0] C_MOVE        = 8'h85;
    localparam logic [7:0] C_ERASE_SETUP = 8'h60;
    localparam logic [7:0] C_ERASE_GO    = 8'hD0;
    localparam logic [7:0] C_COL_SETUP   = 8'h05;
    localparam logic [7:0] C_COL_GO      = 8'hE0;
    localparam logic [7:0] C_ID          = 8'h90;
    localparam logic [7:0] C_STATUS      = 8'h70;
    localparam logic [7:0] C_RESET       = 8'hFF;

    typedef enum logic [2:0] {
        PD_NONE, PD_READ, PD_PROG, PD_COPY, PD_ERASE, PD_RDOUT, PD_RDIN
    } pend_t;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0, OP_READ = 3'd1, OP_READ_CB = 3'd2, OP_PROG = 3'd3,
        OP_CACHE = 3'd4, OP_COPY = 3'd5, OP_ERASE = 3'd6
    } op_t;

    typedef enum logic [1:0] {OUT_ARRAY, OUT_STATUS, OUT_ID} out_t;
endpackage

// File: rtl/nand_fe_edge.sv
// Edge detector for a strobe pin sampled on clk.
// Assumes the pin is already synchronous to clk; IDLE is its level at rest.
module nand_fe_edge #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic prev;

    // Remember the level seen at the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE;
        else        prev <= pin;
    end

    assign rise = pin & ~prev;
    assign fall = ~pin & prev;
endmodule

// File: rtl/nand_fe_seq.sv
// Command sequencer and address assembler.
// Tracks the pending setup command, counts address cycles, fires
// operations on matching confirms and selects the read-out mode.
// Assumes cmd_ev/addr_ev/data_ev are already qualified by chip select.
module nand_fe_seq
    import nand_fe_pkg::*;
#(
    parameter int COL_W = 12,
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_ev,
    input  logic             addr_ev,
    input  logic             data_ev,
    input  logic [7:0]       io_in,
    input  logic             busy,
    output logic             fire,
    output op_t              fire_kind,
    output logic             abort,
    output logic             ptr_load,
    output logic [COL_W-1:0] ptr_val,
    output logic             ptr_clr,
    output logic             buf_we,
    output out_t             mode,
    output logic             op_go,
    output op_t              op_kind,
    output logic [ROW_W-1:0] op_row
);
    pend_t      pend;
    logic [2:0] acnt;
    logic [7:0] col_lo;
    logic [2:0] need;
    logic [2:0] slot;
    logic       full;
    logic       addr_ok;

    assign full    = (acnt == 3'd4);
    assign need    = (pend == PD_ERASE || pend == PD_RDOUT || pend == PD_RDIN) ? 3'd2 : 3'd4;
    assign slot    = (pend == PD_ERASE) ? acnt + 3'd2 : acnt;
    assign addr_ok = addr_ev && !busy && (pend != PD_NONE) && (acnt < need);

    assign ptr_load = addr_ok && (slot == 3'd1);
    assign ptr_val  = {io_in[COL_W-9:0], col_lo};
    assign ptr_clr  = cmd_ev && (io_in == C_RESET || (!busy && io_in == C_ID));
    assign abort    = cmd_ev && busy && (io_in == C_RESET);
    assign buf_we   = data_ev && !busy && full && (pend == PD_PROG || pend == PD_COPY);

    // Decide whether this command confirms a fully addressed setup.
    always_comb begin
        fire      = 1'b0;
        fire_kind = OP_NONE;
        if (cmd_ev && !busy) begin
            case (io_in)
                C_READ_GO:   if (pend == PD_READ && full) begin fire = 1'b1; fire_kind = OP_READ; end
                C_CBREAD_GO: if (pend == PD_READ && full) begin fire = 1'b1; fire_kind = OP_READ_CB; end
                C_PROG_GO: begin
                    if (pend == PD_PROG && full) begin fire = 1'b1; fire_kind = OP_PROG; end
                    else if (pend == PD_COPY && full) begin fire = 1'b1; fire_kind = OP_COPY; end
                end
                C_CACHE_GO:  if (pend == PD_PROG && full) begin fire = 1'b1; fire_kind = OP_CACHE; end
                C_ERASE_GO:  if (pend == PD_ERASE && acnt == 3'd2) begin fire = 1'b1; fire_kind = OP_ERASE; end
                default: ;
            endcase
        end
    end

    // Pending-sequence, address and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= PD_NONE;
            acnt    <= 3'd0;
            col_lo  <= 8'd0;
            op_row  <= '0;
            mode    <= OUT_ARRAY;
            op_go   <= 1'b0;
            op_kind <= OP_NONE;
        end else begin
            op_go <= fire;
            if (fire) op_kind <= fire_kind;
            if (cmd_ev && busy) begin
                if (io_in == C_STATUS) mode <= OUT_STATUS;
                else if (io_in == C_RESET) begin
                    pend <= PD_NONE;
                    acnt <= 3'd0;
                    mode <= OUT_ARRAY;
                end
            end else if (cmd_ev) begin
                pend <= PD_NONE;
                acnt <= 3'd0;
                case (io_in)
                    C_READ_SETUP:  begin pend <= PD_READ; mode <= OUT_ARRAY; end
                    C_PROG_SETUP:  pend <= PD_PROG;
                    C_MOVE:        pend <= (pend == PD_PROG && full) ? PD_RDIN : PD_COPY;
                    C_COL_SETUP:   pend <= PD_RDOUT;
                    C_ERASE_SETUP: pend <= PD_ERASE;
                    C_COL_GO:      if (pend == PD_RDOUT && acnt == 3'd2) mode <= OUT_ARRAY;
                    C_ID:          mode <= OUT_ID;
                    C_STATUS: begin
                        pend <= pend;
                        acnt <= acnt;
                        mode <= OUT_STATUS;
                    end
                    C_RESET:       mode <= OUT_ARRAY;
                    default: ;
                endcase
            end else if (addr_ok) begin
                acnt <= acnt + 3'd1;
                case (slot)
                    3'd0: col_lo <= io_in;
                    3'd2: op_row[7:0] <= io_in;
                    3'd3: op_row[ROW_W-1:8] <= io_in[ROW_W-9:0];
                    default: ;
                endcase
                if (pend == PD_RDIN && slot == 3'd1) begin
                    pend <= PD_PROG;
                    acnt <= 3'd4;
                end
            end
        end
    end
endmodule

// File: rtl/nand_fe_busy.sv
// Busy timer standing in for the array engine.
// Loads a per-kind cycle count on an operation start; ready when zero.
// Assumes every length parameter is at least 1.
module nand_fe_busy
    import nand_fe_pkg::*;
#(
    parameter int T_READ  = 50,
    parameter int T_PROG  = 400,
    parameter int T_CACHE = 60,
    parameter int T_ERASE = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  op_t  fire_kind,
    input  logic abort,
    output logic busy
);
    localparam int TMAX  = (T_ERASE > T_PROG) ? T_ERASE : T_PROG;
    localparam int CNT_W = $clog2(TMAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len;

    // Select the busy length for the operation being started.
    always_comb begin
        case (fire_kind)
            OP_READ, OP_READ_CB: len = CNT_W'(T_READ);
            OP_CACHE:            len = CNT_W'(T_CACHE);
            OP_ERASE:            len = CNT_W'(T_ERASE);
            default:             len = CNT_W'(T_PROG);
        endcase
    end

    // Count down the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (abort)          cnt <= '0;
        else if (fire)           cnt <= len;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/nand_fe_datapath.sv
// Column pointer, behavioural page buffer and output byte register.
// The buffer keeps 2^BUF_AW bytes indexed by the low pointer bits.
module nand_fe_datapath
    import nand_fe_pkg::*;
#(
    parameter int          COLS     = 2112,
    parameter int          COL_W    = 12,
    parameter int          BUF_AW   = 4,
    parameter logic [31:0] ID_BYTES = 32'h9510D1C8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_load,
    input  logic [COL_W-1:0] ptr_val,
    input  logic             ptr_clr,
    input  logic             buf_we,
    input  logic [7:0]       wdata,
    input  logic             rd_step,
    input  logic             busy,
    input  out_t             mode,
    output logic [COL_W-1:0] ptr,
    output logic [7:0]       io_q
);
    localparam int DEPTH = 1 << BUF_AW;

    logic [7:0]       pg [DEPTH];
    logic [COL_W-1:0] ptr_nx;
    logic             step_ok;

    assign ptr_nx  = (ptr == COL_W'(COLS - 1)) ? '0 : ptr + 1'b1;
    assign step_ok = rd_step && !busy && (mode != OUT_STATUS);

    // Column pointer: clear, load, or advance on write or read.
    always_ff @(posedge clk) begin
        if (!rst_n || ptr_clr)       ptr <= '0;
        else if (ptr_load)           ptr <= ptr_val;
        else if (buf_we || step_ok)  ptr <= ptr_nx;
    end

    // Page buffer write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pg[i] <= 8'd0;
        end else if (buf_we) begin
            pg[ptr[BUF_AW-1:0]] <= wdata;
        end
    end

    // Output byte loaded on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) io_q <= 8'd0;
        else if (rd_step) begin
            case (mode)
                OUT_STATUS: io_q <= {1'b0, ~busy, 6'd0};
                OUT_ID:     io_q <= ID_BYTES[8*ptr[1:0] +: 8];
                default:    io_q <= pg[ptr[BUF_AW-1:0]];
            endcase
        end
    end
endmodule

// File: rtl/nand_cmd_frontend.sv
// NAND device command front-end top level.
// Qualifies bus strobes, runs the command sequencer, busy timer and
// read datapath, and drives the bus enable. Pins are assumed synchronous.
module nand_cmd_frontend
    import nand_fe_pkg::*;
#(
    parameter int          COLS     = 2112,
    parameter int          ROW_W    = 16,
    parameter int          BUF_AW   = 4,
    parameter int          T_READ   = 50,
    parameter int          T_PROG   = 400,
    parameter int          T_CACHE  = 60,
    parameter int          T_ERASE  = 3000,
    parameter logic [31:0] ID_BYTES = 32'h9510D1C8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             cle,
    input  logic             ale,
    input  logic             we_n,
    input  logic             re_n,
    input  logic [7:0]       io_in,
    output logic [7:0]       io_out,
    output logic             io_oe,
    output logic             rb,
    output logic             op_go,
    output logic [2:0]       op_kind,
    output logic [ROW_W-1:0] op_row
);
    localparam int COL_W = $clog2(COLS);

    logic             we_rise, we_fall_nc, re_rise_nc, re_fall;
    logic             wr_ok, cmd_ev, addr_ev, data_ev, rd_step;
    logic             busy, fire, abort;
    op_t              fire_kind, kind_q;
    logic             ptr_load, ptr_clr, buf_we;
    logic [COL_W-1:0] ptr_val, ptr;
    out_t             mode;
    logic             step_mode;

    nand_fe_edge #(.IDLE(1'b1)) u_we (.clk(clk), .rst_n(rst_n), .pin(we_n), .rise(we_rise), .fall(we_fall_nc));
    nand_fe_edge #(.IDLE(1'b1)) u_re (.clk(clk), .rst_n(rst_n), .pin(re_n), .rise(re_rise_nc), .fall(re_fall));

    assign wr_ok   = we_rise & ~ce_n;
    assign cmd_ev  = wr_ok & cle & ~ale;
    assign addr_ev = wr_ok & ale & ~cle;
    assign data_ev = wr_ok & ~cle & ~ale;
    assign rd_step = re_fall & ~ce_n;

    nand_fe_seq #(.COL_W(COL_W), .ROW_W(ROW_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_ev(cmd_ev), .addr_ev(addr_ev), .data_ev(data_ev),
        .io_in(io_in), .busy(busy), .fire(fire), .fire_kind(fire_kind), .abort(abort),
        .ptr_load(ptr_load), .ptr_val(ptr_val), .ptr_clr(ptr_clr), .buf_we(buf_we),
        .mode(mode), .op_go(op_go), .op_kind(kind_q), .op_row(op_row)
    );

    nand_fe_busy #(.T_READ(T_READ), .T_PROG(T_PROG), .T_CACHE(T_CACHE), .T_ERASE(T_ERASE)) u_busy (
        .clk(clk), .rst_n(rst_n), .fire(fire), .fire_kind(fire_kind), .abort(abort), .busy(busy)
    );

    nand_fe_datapath #(.COLS(COLS), .COL_W(COL_W), .BUF_AW(BUF_AW), .ID_BYTES(ID_BYTES)) u_dp (
        .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_val(ptr_val), .ptr_clr(ptr_clr),
        .buf_we(buf_we), .wdata(io_in), .rd_step(rd_step), .busy(busy), .mode(mode),
        .ptr(ptr), .io_q(io_out)
    );

    assign step_mode = (mode != OUT_STATUS);
    assign op_kind   = kind_q;
    assign rb        = ~busy;
    assign io_oe     = (~ce_n | busy) & ~re_n;
endmodule

// File: rtl/nand_fe_checker.sv
// Property checker for nand_cmd_frontend, attached by bind.
// Observes ports plus the column pointer and read-out mode.
module nand_fe_checker #(
    parameter int COLS  = 2112,
    parameter int COL_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             we_n,
    input logic             re_n,
    input logic             rb,
    input logic             io_oe,
    input logic             op_go,
    input logic [COL_W-1:0] ptr,
    input logic             step_mode
);
    // R11: bus released when deselected and idle
    assert_oe_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && rb) |-> !io_oe);

    // R5: a busy period only ever begins with an operation start
    assert_busy_needs_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb) |-> op_go);

    // R5: start pulse lasts one cycle
    assert_go_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_go |=> !op_go);

    // R9: no new operation is started while already busy
    assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rb && $past(!rb)) |-> !op_go);

    // R7: pointer stays inside the page
    assert_ptr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < COL_W'(COLS));

    // R6: a read strobe while ready in array/ID mode advances the pointer by one
    assert_read_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(re_n) && !ce_n && rb && step_mode && we_n && $stable(we_n))
        |=> ptr == (($past(ptr) == COL_W'(COLS - 1)) ? '0 : $past(ptr) + 1'b1));
endmodule

bind nand_cmd_frontend nand_fe_checker #(.COLS(COLS), .COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .re_n(re_n), .rb(rb),
    .io_oe(io_oe), .op_go(op_go), .ptr(ptr), .step_mode(step_mode)
);

// File: tb/nand_cmd_frontend_bench.sv
// Self-checking bench for nand_cmd_frontend with short busy lengths.
module nand_cmd_frontend_bench;
    localparam int          COLS = 2112;
    localparam int          TR = 5, TP = 12, TC = 3, TE = 20;
    localparam logic [31:0] IDW = 32'hA1B2C3D4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [7:0]  io_in = 8'd0;
    logic [7:0]  io_out;
    logic        io_oe, rb, op_go;
    logic [2:0]  op_kind;
    logic [15:0] op_row;

    int n_chk = 0, n_bad = 0;
    logic [7:0] eb [16];

    always #2.5 clk = ~clk;

    nand_cmd_frontend #(.COLS(COLS), .ROW_W(16), .BUF_AW(4), .T_READ(TR), .T_PROG(TP),
        .T_CACHE(TC), .T_ERASE(TE), .ID_BYTES(IDW)) u_nand_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rb(rb),
        .op_go(op_go), .op_kind(op_kind), .op_row(op_row));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic a, input logic [7:0] d);
        @(negedge clk); cle = c; ale = a; io_in = d; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] d);  wr(1'b1, 1'b0, d); endtask
    task automatic adr(input logic [7:0] d);  wr(1'b0, 1'b1, d); endtask
    task automatic din(input logic [7:0] d);  wr(1'b0, 1'b0, d); endtask

    task automatic rd(output logic [7:0] d);
        @(negedge clk); re_n = 1'b0;
        @(negedge clk); d = io_out; re_n = 1'b1;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (rb == 1'b0 && n < 100000) begin n++; @(negedge clk); end
    endtask

    task automatic addr4(input int col, input int row);
        adr(8'(col)); adr(8'(col >> 8)); adr(8'(row)); adr(8'(row >> 8));
    endtask

    // Read three bytes from column c of the page (R6, R7, R5).
    task automatic read_at(input int c);
        int n; logic [7:0] d;
        cmd(8'h00); addr4(c, 16'h0007); cmd(8'h30);
        chk("R5 read kind", op_kind, 1);
        wait_ready(n);
        chk("R8 read busy length", n, TR);
        for (int k = 0; k < 3; k++) begin
            rd(d);
            chk("R6/R7 read byte", d, eb[((c + k) % COLS) % 16]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int n; logic [7:0] d;
        int sp[5] = '{2040, 2047, 2048, 2100, 2111};
        for (int i = 0; i < 16; i++) eb[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset rb", rb, 1);
        chk("R8 reset oe", io_oe, 0);
        chk("R8 reset go", op_go, 0);
        chk("R8 reset io_out", io_out, 0);

        // R11: deselected and idle keeps bus released
        ce_n = 1'b1;
        @(negedge clk); re_n = 1'b0; @(negedge clk);
        chk("R11 oe deselected", io_oe, 0);
        re_n = 1'b1; ce_n = 1'b0;

        // R1: confirm with chip deselected is ignored, pending survives
        cmd(8'h80); addr4(0, 16'h0321);
        ce_n = 1'b1; cmd(8'h10);
        chk("R1 no start when deselected", op_go, 0);
        chk("R1 still ready", rb, 1);
        ce_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            din(8'((i * 37 + 5) & 255));
            eb[i] = 8'((i * 37 + 5) & 255);
        end
        cmd(8'h10);
        chk("R5 program go", op_go, 1);
        chk("R5 program kind", op_kind, 3);
        chk("R2 row assembled", op_row, 16'h0321);
        wait_ready(n);
        chk("R8 program busy length", n, TP);

        // R6/R7 sweep over start columns
        for (int c = 0; c < 16; c++) read_at(c);
        for (int j = 0; j < 5; j++) read_at(sp[j]);

        // R3: upper nibble of column high discarded, extra cycle ignored
        cmd(8'h00); adr(8'h05); adr(8'hF0); adr(8'h00); adr(8'h00); adr(8'h0A);
        cmd(8'h30);
        chk("R3 confirm after extra cycle", op_go, 1);
        wait_ready(n);
        rd(d);
        chk("R3 column upper nibble dropped", d, eb[5]);

        // R13: random data output, no busy
        cmd(8'h05); adr(8'h0C); adr(8'h00); cmd(8'hE0);
        chk("R13 no busy", rb, 1);
        chk("R13 no start", op_go, 0);
        rd(d); chk("R13 byte at new column", d, eb[12]);
        rd(d); chk("R13 next byte", d, eb[13]);

        // R12: identification bytes
        cmd(8'h90); adr(8'h00);
        for (int k = 0; k < 5; k++) begin
            rd(d);
            chk("R12 id byte", d, int'(IDW >> (8 * (k % 4))) & 255);
        end

        // R14: random data input inside a program
        cmd(8'h80); addr4(0, 0);
        din(8'h11); eb[0] = 8'h11;
        din(8'h22); eb[1] = 8'h22;
        cmd(8'h85); adr(8'h0A); adr(8'h00);
        din(8'h33); eb[10] = 8'h33;
        cmd(8'h10);
        chk("R14 program continues", op_kind, 3);
        wait_ready(n);
        read_at(0);
        read_at(10);

        // R4: erase with two row cycles
        cmd(8'h60); adr(8'h34); adr(8'h02); cmd(8'hD0);
        chk("R4 erase kind", op_kind, 6);
        chk("R4 erase row", op_row, 16'h0234);
        wait_ready(n);
        chk("R4 erase busy length", n, TE);

        // R9: only status and reset act while busy
        cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0);
        cmd(8'h70);
        rd(d); chk("R9 status while busy", d, 8'h00);
        cmd(8'h00);
        rd(d); chk("R9 read setup ignored while busy", d, 8'h00);
        ce_n = 1'b1;
        @(negedge clk); re_n = 1'b0; @(negedge clk);
        chk("R11 oe held while busy", io_oe, 1);
        re_n = 1'b1; ce_n = 1'b0;
        wait_ready(n);
        rd(d); chk("R9 status when ready", d, 8'h40);
        cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0);
        chk("R9 busy before abort", rb, 0);
        cmd(8'hFF);
        chk("R9 abort returns ready", rb, 1);

        // R10: mismatched and undefined commands
        cmd(8'h00); addr4(0, 1); cmd(8'hD0);
        chk("R10 mismatched confirm", op_go, 0);
        cmd(8'h30);
        chk("R10 pending cleared", op_go, 0);
        chk("R10 still ready", rb, 1);
        cmd(8'h80); addr4(0, 1); cmd(8'hAB); cmd(8'h10);
        chk("R10 undefined clears", op_go, 0);
        cmd(8'h00); adr(8'h00); adr(8'h00); cmd(8'h30);
        chk("R10 early confirm", op_go, 0);

        // R5: cache program, read for copy-back, copy-back program
        cmd(8'h80); addr4(0, 5); cmd(8'h15);
        chk("R5 cache kind", op_kind, 4);
        wait_ready(n); chk("R5 cache busy length", n, TC);
        cmd(8'h00); addr4(0, 5); cmd(8'h35);
        chk("R5 copy read kind", op_kind, 2);
        wait_ready(n); chk("R5 copy read busy length", n, TR);
        cmd(8'h85); addr4(0, 16'h0106); cmd(8'h10);
        chk("R5 copy program kind", op_kind, 5);
        chk("R2 copy row", op_row, 16'h0106);
        wait_ready(n); chk("R5 copy program busy length", n, TP);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule